// File: doc/BRIEF.md
# Whole-Register Parity Keystream Generator

This block is a small feedback shift register that produces one keystream bit per enabled clock and combines it with a serial plaintext bit to form a ciphertext bit. On each step the register moves one place toward its most significant end. The vacated low bit takes the exclusive-OR of every bit the register held before the move. No tap selection is involved, so the sequence is short and depends only on the seed. The block suits bring-up, demonstration and test-pattern work, and it gives no cryptographic strength.

A seed word is written with a load strobe. After that, each cycle with the enable high advances the register by one step. It also registers the pre-step most significant bit as the keystream bit and the XOR of that bit with the plaintext bit as the ciphertext bit. Running the same seed over the ciphertext returns the plaintext. A step counter reports how many shifts have happened since the last load, which makes the period easy to measure. The register state is also brought out.

Top module: `xorfold_keystream`

## Requirements
- R1: On an enabled step without load, bits [W-1:1] of the new state equal bits [W-2:0] of the old state.
- R2: On an enabled step without load, bit 0 of the new state equals the XOR of all W bits of the old state.
- R3: With W=4 and seed 4'b0101, the first two enabled steps give states 4'b1010 and then 4'b0100.
- R4: With W=4 and seed 4'b0101, the state is 4'b0101 again after exactly five enabled steps and not earlier.
- R5: After an enabled step, the keystream output equals the most significant bit of the state before that step.
- R6: After an enabled step, the ciphertext output equals the plaintext input at that edge XOR the new keystream output. Re-running the same seed over the ciphertext gives back the plaintext.
- R7: A load at a clock edge sets the state to the seed and the step count to zero, even if enable is also high. The keystream and ciphertext outputs do not change on that edge.
- R8: When enable and load are both low, the state, step count, keystream and ciphertext outputs hold, whatever the plaintext input does.
- R9: A synchronous reset clears the state, step count, keystream and ciphertext to zero. An all-zero state stays all zero and produces a zero keystream when enabled.
- R10: The step count goes up by one on each enabled step without load, and wraps from 2^CW-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Write the seed word into the register |
| seed | input | W | Seed word |
| en | input | 1 | Advance one step |
| pt_bit | input | 1 | Plaintext bit |
| ks_bit | output | 1 | Registered keystream bit |
| ct_bit | output | 1 | Registered ciphertext bit |
| state | output | W | Current register contents |
| steps | output | CW | Shifts since the last load, wrapping |

## Verification
A wrong feedback bit first shows on the state port one cycle after the bad step. It then reaches the keystream port once it has moved up to the top bit, which takes up to W-1 further steps. From that point the keystream and ciphertext diverge for the rest of the run. For that reason the bench compares the full state every cycle and does not rely on the serial outputs alone. A counter error appears on the step port at the next edge, and a period check from a known seed catches it as well.

// File: rtl/xorfold_keystream.sv
module xorfold_keystream #(
  parameter int W  = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  seed,
  input  logic          en,
  input  logic          pt_bit,
  output logic          ks_bit,
  output logic          ct_bit,
  output logic [W-1:0]  state,
  output logic [CW-1:0] steps
);

  logic [W-1:0] reg_q;
  logic         fb;
  logic         advance;

  assign fb      = ^reg_q;
  assign advance = en && !load;
  assign state   = reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q  <= '0;
      steps  <= '0;
      ks_bit <= 1'b0;
      ct_bit <= 1'b0;
    end else if (load) begin
      reg_q <= seed;
      steps <= '0;
    end else if (en) begin
      reg_q  <= {reg_q[W-2:0], fb};
      steps  <= steps + 1'b1;
      ks_bit <= reg_q[W-1];
      ct_bit <= pt_bit ^ reg_q[W-1];
    end
  end

  // R1
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> state[W-1:1] == $past(state[W-2:0]));

  // R2
  fill_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> state[0] == ^$past(state));

  // R5
  ks_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> ks_bit == $past(state[W-1]));

  // R6
  ct_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> ct_bit == ($past(pt_bit) ^ ks_bit));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed) && steps == '0 && $stable(ks_bit) && $stable(ct_bit));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(state) && $stable(steps) && $stable(ks_bit) && $stable(ct_bit));

  // R9
  zero_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && state == '0) |=> state == '0 && ks_bit == 1'b0);

  // R10
  count_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> steps == $past(steps) + 1'b1);

endmodule

// File: tb/tb_xorfold_keystream.sv
module tb_xorfold_keystream;
  localparam int W  = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst, load, en, pt_bit;
  logic [W-1:0]  seed;
  logic          ks_bit, ct_bit;
  logic [W-1:0]  state;
  logic [CW-1:0] steps;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0]  m_st;
  logic [CW-1:0] m_cnt;
  logic          m_ks, m_ct;

  always #2.5 clk = ~clk;

  xorfold_keystream #(.W(W), .CW(CW)) dut (
    .clk(clk), .rst(rst), .load(load), .seed(seed), .en(en),
    .pt_bit(pt_bit), .ks_bit(ks_bit), .ct_bit(ct_bit),
    .state(state), .steps(steps)
  );

  function automatic logic [W-1:0] next_st(input logic [W-1:0] s);
    return {s[W-2:0], ^s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic l, input logic [W-1:0] s,
                       input logic e, input logic p);
    @(negedge clk);
    rst = r; load = l; seed = s; en = e; pt_bit = p;
    if (r) begin
      m_st = '0; m_cnt = '0; m_ks = 1'b0; m_ct = 1'b0;
    end else if (l) begin
      m_st = s; m_cnt = '0;
    end else if (e) begin
      m_ks = m_st[W-1];
      m_ct = p ^ m_st[W-1];
      m_st = next_st(m_st);
      m_cnt = m_cnt + 1'b1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string req);
    check({req, " state"}, 32'(state), 32'(m_st));
    check({req, " steps"}, 32'(steps), 32'(m_cnt));
    check({req, " ks"}, 32'(ks_bit), 32'(m_ks));
    check({req, " ct"}, 32'(ct_bit), 32'(m_ct));
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [63:0] ptv, ctv;
    rst = 1'b1; load = 1'b0; en = 1'b0; pt_bit = 1'b0; seed = '0;
    rv = $urandom(32'h1F2E3D4C);
    drive(1, 0, 4'h0, 0, 0);
    drive(1, 0, 4'h0, 0, 0);
    check_all("R9 reset");

    // R9 zero fixed point
    for (int i = 0; i < 6; i++) begin
      drive(0, 0, 4'h0, 1, 1'(i));
      check("R9 zero state", 32'(state), 0);
      check("R9 zero ks", 32'(ks_bit), 0);
    end

    // R7 load wins over enable
    drive(0, 1, 4'b0101, 1, 1);
    check("R7 load state", 32'(state), 32'h5);
    check("R7 load steps", 32'(steps), 0);
    check_all("R7");

    drive(0, 0, 4'h0, 1, 0);
    check("R3 first state", 32'(state), 32'hA);
    check("R5 ks", 32'(ks_bit), 0);
    drive(0, 0, 4'h0, 1, 0);
    check("R3 second state", 32'(state), 32'h4);
    check("R5 ks", 32'(ks_bit), 1);
    drive(0, 0, 4'h0, 1, 0);
    check("R4 not early", 32'(state == 4'b0101), 0);
    drive(0, 0, 4'h0, 1, 0);
    check("R4 not early", 32'(state == 4'b0101), 0);
    drive(0, 0, 4'h0, 1, 0);
    check("R4 period", 32'(state), 32'h5);
    check("R10 steps", 32'(steps), 5);

    // R8 hold while plaintext toggles
    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 4'hF, 0, 1'(i));
      check_all("R8 hold");
    end

    // R1 R2 R5 R6 R8 random mix
    for (int i = 0; i < 3000; i++) begin
      rv = $urandom;
      drive(0, rv[3:0] == 0, rv[7:4], rv[9:8] != 0, rv[10]);
      check_all("R1 R2 R5 R6 random");
    end

    // R6 encrypt then decrypt
    for (int t = 0; t < 8; t++) begin
      logic [W-1:0] sd;
      sd = 4'($urandom);
      ptv = {$urandom, $urandom};
      drive(0, 1, sd, 0, 0);
      for (int i = 0; i < 64; i++) begin
        drive(0, 0, 4'h0, 1, ptv[i]);
        ctv[i] = ct_bit;
      end
      drive(0, 1, sd, 0, 0);
      for (int i = 0; i < 64; i++) begin
        drive(0, 0, 4'h0, 1, ctv[i]);
        check("R6 roundtrip", 32'(ct_bit), 32'(ptv[i]));
      end
    end

    // R10 wrap
    drive(0, 1, 4'b0011, 0, 0);
    for (int i = 0; i < (1 << CW) - 1; i++) drive(0, 0, 4'h0, 1, 0);
    check("R10 max", 32'(steps), (1 << CW) - 1);
    drive(0, 0, 4'h0, 1, 0);
    check("R10 wrap", 32'(steps), 0);
    check_all("R10");

    drive(1, 0, 4'h0, 1, 1);
    check_all("R9 late reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule